// File: doc/BRIEF.md
# Digit-serial Barrett modular multiplier

This block computes T = A·B mod M for n-bit operands by scanning the multiplier B one w-bit digit at a time, starting with the most significant digit. At each digit step the running remainder is shifted up by one digit and A times the digit is added to it. A quotient estimate is then formed from the top bits of the remainder and a precomputed reciprocal, and that estimate times M is subtracted. The block does not divide at any point. After the last digit, a single conditional subtraction of M brings the result into the range [0, M).

The caller supplies A, B, M and the reciprocal mu = floor(2^(n+w+3) / M), then pulses a start input. Producing mu is the caller's job. All products come from one (w+4)×(w+4) multiplier that is shared over time and issues one product per cycle. A digit step takes nw partial products of A, one quotient estimate and nw partial products of the modulus. The block reports busy while it runs and raises done for one cycle when the result is ready.

Top module: `barrett_mm`

## Requirements
- R1: While rst_ni is low, and in the cycle after it is released, busy_o = 0, done_o = 0 and t_o = 0.
- R2: When start_i is high in a cycle where busy_o is low, the block captures a_i, b_i, m_i and mu_i. busy_o is high from the next cycle until the cycle in which done_o rises.
- R3: The operands must satisfy 2^(n-1) < M < 2^n, 0 ≤ A, B < M and mu_i = floor(2^(n+w+3)/M). When done_o is high, t_o equals A·B mod M, which is always below M.
- R4: The internal remainder never needs more than n+w+2 bits during the run, including when A = B = M−1.
- R5: done_o rises exactly nw·(2·nw+1)+1 clock edges after the edge that accepted start. That is one product per cycle for 2·nw²+nw cycles plus one correction cycle, and equals 37 when n = 64 and w = 16.
- R6: done_o is high for exactly one cycle.
- R7: t_o keeps its value from one done_o pulse to the next. Changes on a_i, b_i, m_i or mu_i while idle have no effect on it.
- R8: A start_i pulse while busy_o is high is ignored. The running operation keeps its operands, its result and its timing.
- R9: A start_i that is high in the same cycle as done_o is accepted, so a new operation follows without an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a multiplication (sampled while idle) |
| a_i | input | N_BITS | Multiplicand A |
| b_i | input | N_BITS | Multiplier B, scanned from the top digit down |
| m_i | input | N_BITS | Modulus M, top bit set |
| mu_i | input | W_BITS+4 | Reciprocal floor(2^(n+w+3)/M) |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse when t_o is valid |
| t_o | output | N_BITS | Result A·B mod M |

## Verification
Four properties are checked on every cycle: the remainder stays within n+w+2 bits, done is a single-cycle pulse, t_o changes only together with done, and a result is always below the latched modulus. A cycle counter inside the checker also ties each done pulse to the start that was accepted, so a restart or a stall would be flagged. The arithmetic correctness of t_o can only be shown by the bench scenarios. These compare the result against a wide-integer product taken modulo M, for random operands and for the extremes: zero, M−1 squared, the smallest and largest allowed moduli, and back-to-back and interrupted starts.

// File: rtl/bmm_pkg.sv
package bmm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MAB,   // A_j * B_i accumulate
    ST_QEST,  // quotient estimate
    ST_QM,    // q * M_j subtract
    ST_FIX    // final conditional subtract
  } bmm_state_e;
endpackage

// File: rtl/bmm_sp_mul.sv
module bmm_sp_mul #(
  parameter int LAM = 20
) (
  input  logic [LAM-1:0]   x_i,
  input  logic [LAM-1:0]   y_i,
  output logic [2*LAM-1:0] p_o
);
  assign p_o = (2*LAM)'(x_i) * (2*LAM)'(y_i);
endmodule

// File: rtl/bmm_ctrl.sv
module bmm_ctrl
  import bmm_pkg::*;
#(
  parameter int NW    = 4,
  parameter int CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output bmm_state_e       state_o,
  output logic [CNT_W-1:0] dig_i_o,
  output logic [CNT_W-1:0] dig_j_o,
  output logic             load_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NW - 1);

  bmm_state_e       state_q;
  logic [CNT_W-1:0] i_q, j_q;
  logic             done_q;

  assign load_o  = (state_q == ST_IDLE) && start_i;
  assign busy_o  = (state_q != ST_IDLE);
  assign state_o = state_q;
  assign dig_i_o = i_q;
  assign dig_j_o = j_q;
  assign done_o  = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      i_q     <= '0;
      j_q     <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= (state_q == ST_FIX);
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_MAB;
          i_q     <= LAST;
          j_q     <= '0;
        end
        ST_MAB: begin
          if (j_q == LAST) begin
            j_q     <= '0;
            state_q <= ST_QEST;
          end else begin
            j_q <= j_q + 1'b1;
          end
        end
        ST_QEST: state_q <= ST_QM;
        ST_QM: begin
          if (j_q == LAST) begin
            j_q <= '0;
            if (i_q == '0) begin
              state_q <= ST_FIX;
            end else begin
              i_q     <= i_q - 1'b1;
              state_q <= ST_MAB;
            end
          end else begin
            j_q <= j_q + 1'b1;
          end
        end
        ST_FIX:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bmm_datapath.sv
module bmm_datapath
  import bmm_pkg::*;
#(
  parameter int N_BITS = 64,
  parameter int W_BITS = 16,
  parameter int LAM    = 20,
  parameter int ACC_W  = 85,
  parameter int CNT_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  bmm_state_e        state_i,
  input  logic [CNT_W-1:0]  dig_i_i,
  input  logic [CNT_W-1:0]  dig_j_i,
  input  logic [N_BITS-1:0] a_i,
  input  logic [N_BITS-1:0] b_i,
  input  logic [N_BITS-1:0] m_i,
  input  logic [LAM-1:0]    mu_i,
  output logic [N_BITS-1:0] t_o,
  output logic [N_BITS-1:0] m_lat_o,
  output logic [ACC_W-1:0]  acc_o
);
  localparam int Q_SH   = W_BITS + 5;  // alpha - beta
  localparam int TOP_SH = N_BITS - 2;  // n + beta

  logic [N_BITS-1:0] a_q, b_q, m_q, t_q;
  logic [LAM-1:0]    mu_q, q_q;
  logic [ACC_W-1:0]  acc_q, acc_base, prod_sh, acc_nxt, m_ext;
  logic [LAM-1:0]    op_x, op_y;
  logic [2*LAM-1:0]  prod;
  logic [W_BITS-1:0] a_dig, b_dig, m_dig;

  assign a_dig = a_q[dig_j_i*W_BITS +: W_BITS];
  assign b_dig = b_q[dig_i_i*W_BITS +: W_BITS];
  assign m_dig = m_q[dig_j_i*W_BITS +: W_BITS];
  assign m_ext = ACC_W'(m_q);

  always_comb begin
    op_x = '0;
    op_y = '0;
    unique case (state_i)
      ST_MAB:  begin op_x = LAM'(a_dig); op_y = LAM'(b_dig); end
      ST_QEST: begin op_x = acc_q[TOP_SH +: LAM]; op_y = mu_q; end
      ST_QM:   begin op_x = q_q; op_y = LAM'(m_dig); end
      default: ;
    endcase
  end

  bmm_sp_mul #(.LAM(LAM)) u_mul (.x_i(op_x), .y_i(op_y), .p_o(prod));

  assign prod_sh  = ACC_W'(prod) << (dig_j_i * W_BITS);
  assign acc_base = (state_i == ST_MAB && dig_j_i == '0) ? (acc_q << W_BITS) : acc_q;

  always_comb begin
    unique case (state_i)
      ST_MAB:  acc_nxt = acc_base + prod_sh;
      ST_QM:   acc_nxt = acc_q - prod_sh;
      default: acc_nxt = acc_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q   <= '0;
      b_q   <= '0;
      m_q   <= '0;
      mu_q  <= '0;
      q_q   <= '0;
      acc_q <= '0;
      t_q   <= '0;
    end else if (load_i) begin
      a_q   <= a_i;
      b_q   <= b_i;
      m_q   <= m_i;
      mu_q  <= mu_i;
      acc_q <= '0;
    end else begin
      acc_q <= acc_nxt;
      if (state_i == ST_QEST) q_q <= LAM'(prod >> Q_SH);
      if (state_i == ST_FIX)
        t_q <= N_BITS'((acc_q >= m_ext) ? (acc_q - m_ext) : acc_q);
    end
  end

  assign t_o     = t_q;
  assign m_lat_o = m_q;
  assign acc_o   = acc_q;
endmodule

// File: rtl/barrett_mm.sv
module barrett_mm
  import bmm_pkg::*;
#(
  parameter int N_BITS = 64,
  parameter int W_BITS = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [N_BITS-1:0]   a_i,
  input  logic [N_BITS-1:0]   b_i,
  input  logic [N_BITS-1:0]   m_i,
  input  logic [W_BITS+3:0]   mu_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [N_BITS-1:0]   t_o
);
  localparam int NW    = N_BITS / W_BITS;
  localparam int LAM   = W_BITS + 4;
  localparam int ACC_W = N_BITS + LAM + 1;
  localparam int CNT_W = (NW > 1) ? $clog2(NW) : 1;

  bmm_state_e       state;
  logic [CNT_W-1:0] dig_i, dig_j;
  logic             load;
  logic [N_BITS-1:0] m_lat;
  logic [ACC_W-1:0]  acc;

  bmm_ctrl #(.NW(NW), .CNT_W(CNT_W)) u_ctrl (
    .clk_i, .rst_ni, .start_i,
    .state_o(state), .dig_i_o(dig_i), .dig_j_o(dig_j),
    .load_o(load), .busy_o, .done_o
  );

  bmm_datapath #(
    .N_BITS(N_BITS), .W_BITS(W_BITS), .LAM(LAM), .ACC_W(ACC_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk_i, .rst_ni,
    .load_i(load), .state_i(state), .dig_i_i(dig_i), .dig_j_i(dig_j),
    .a_i, .b_i, .m_i, .mu_i,
    .t_o, .m_lat_o(m_lat), .acc_o(acc)
  );
endmodule

// File: rtl/bmm_checker.sv
module bmm_checker #(
  parameter int N_BITS = 64,
  parameter int W_BITS = 16
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         start_i,
  input logic                         busy_o,
  input logic                         done_o,
  input logic [N_BITS-1:0]            t_o,
  input logic [N_BITS-1:0]            m_lat,
  input logic [N_BITS+W_BITS+4:0]     acc
);
  localparam int NW  = N_BITS / W_BITS;
  localparam int LAT = NW * (2 * NW + 1) + 1;

  int run_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_cnt <= 0;
    else if (start_i && !busy_o) run_cnt <= 0;
    else if (busy_o) run_cnt <= run_cnt + 1;
  end

  // R2
  a_r2_busy_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
  // R3
  a_r3_below_mod: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (t_o < m_lat));
  // R4
  a_r4_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (acc[N_BITS+W_BITS+4:N_BITS+W_BITS+2] == '0));
  // R5, R8
  a_r5_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (run_cnt == LAT));
  // R6
  a_r6_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R7
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(t_o) |-> done_o);
endmodule

bind barrett_mm bmm_checker #(.N_BITS(N_BITS), .W_BITS(W_BITS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .t_o(t_o), .m_lat(m_lat), .acc(acc)
);

// File: tb/tb_barrett_mm.sv
`timescale 1ns/1ps
module tb_barrett_mm;
  localparam int N   = 64;
  localparam int W   = 16;
  localparam int NW  = N / W;
  localparam int LAT = NW * (2 * NW + 1) + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [N-1:0]  a = '0, b = '0, m = '0;
  logic [W+3:0]  mu = '0;
  logic          busy, done;
  logic [N-1:0]  t;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  barrett_mm #(.N_BITS(N), .W_BITS(W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .a_i(a), .b_i(b), .m_i(m), .mu_i(mu),
    .busy_o(busy), .done_o(done), .t_o(t)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] ref_mod(input logic [N-1:0] x, input logic [N-1:0] y, input logic [N-1:0] md);
    logic [127:0] p;
    p = {64'd0, x} * {64'd0, y};
    return N'(p % {64'd0, md});
  endfunction

  function automatic logic [W+3:0] calc_mu(input logic [N-1:0] md);
    logic [127:0] q;
    q = (128'd1 << (N + W + 3)) / {64'd0, md};
    return (W+4)'(q);
  endfunction

  function automatic logic [N-1:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  // drive at a negedge; returns at the negedge after the accepting edge
  task automatic start_op(input logic [N-1:0] x, input logic [N-1:0] y, input logic [N-1:0] md);
    a = x; b = y; m = md; mu = calc_mu(md);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int lat);
    lat = 0;
    do begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end while (!done && lat < 1000);
  endtask

  task automatic run_chk(input logic [N-1:0] x, input logic [N-1:0] y, input logic [N-1:0] md, input string tag);
    int lat;
    logic [N-1:0] e;
    e = ref_mod(x, y, md);
    start_op(x, y, md);
    chk(busy == 1'b1, "R2 busy after start", busy, 1);
    wait_done(lat);
    chk(lat == LAT, {"R5 latency ", tag}, lat, LAT);
    chk(t == e, {"R3 result ", tag}, t, e);
  endtask

  task automatic t_reset();
    chk(busy == 1'b0, "R1 busy in reset", busy, 0);
    chk(done == 1'b0, "R1 done in reset", done, 0);
    chk(t == '0, "R1 t in reset", t, 0);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0 && t == '0, "R1 after release", {busy, done}, 0);
  endtask

  task automatic t_random();
    for (int k = 0; k < 20; k++) begin
      logic [N-1:0] md;
      md = rnd64() | {1'b1, {(N-2){1'b0}}, 1'b1};
      run_chk(rnd64() % md, rnd64() % md, md, "random");
    end
  endtask

  task automatic t_edges();
    logic [N-1:0] md;
    md = rnd64() | {1'b1, {(N-2){1'b0}}, 1'b1};
    run_chk('0, md - 1, md, "zero a");
    run_chk(md - 1, '0, md, "zero b");
    run_chk(64'd1, 64'd1, md, "one");
    run_chk(md - 1, md - 1, md, "R4 max operands");
    md = {1'b1, {(N-2){1'b0}}, 1'b1};
    run_chk(md - 1, md - 1, md, "R4 smallest modulus");
    md = '1;
    run_chk(md - 1, md - 1, md, "R4 largest modulus");
    run_chk(md - 2, md - 3, md, "largest modulus mixed");
  endtask

  task automatic t_busy_ignore();
    int lat;
    logic [N-1:0] md, x, y, e;
    md = rnd64() | {1'b1, {(N-2){1'b0}}, 1'b1};
    x = rnd64() % md; y = rnd64() % md;
    e = ref_mod(x, y, md);
    start_op(x, y, md);
    repeat (5) @(negedge clk);
    a = rnd64(); b = rnd64(); m = '1; mu = calc_mu('1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(lat);
    chk(lat == LAT - 6, "R8 timing unchanged", lat, LAT - 6);
    chk(t == e, "R8 result of first op", t, e);
  endtask

  task automatic t_done_hold();
    logic [N-1:0] held;
    logic [N-1:0] md;
    md = rnd64() | {1'b1, {(N-2){1'b0}}, 1'b1};
    run_chk(rnd64() % md, rnd64() % md, md, "hold setup");
    held = t;
    @(negedge clk);
    chk(done == 1'b0, "R6 done one cycle", done, 0);
    for (int k = 0; k < 10; k++) begin
      a = rnd64(); b = rnd64(); m = rnd64(); mu = (W+4)'($urandom);
      @(negedge clk);
    end
    chk(t == held, "R7 t held while idle", t, held);
    chk(busy == 1'b0 && done == 1'b0, "R7 stays idle", {busy, done}, 0);
  endtask

  task automatic t_back_to_back();
    int lat;
    logic [N-1:0] md, x, y, e;
    md = rnd64() | {1'b1, {(N-2){1'b0}}, 1'b1};
    x = rnd64() % md; y = rnd64() % md;
    start_op(x, y, md);
    wait_done(lat);
    chk(t == ref_mod(x, y, md), "R9 first result", t, ref_mod(x, y, md));
    x = rnd64() % md; y = rnd64() % md;
    e = ref_mod(x, y, md);
    start_op(x, y, md);  // start high during the done cycle
    chk(busy == 1'b1, "R9 accepted in done cycle", busy, 1);
    wait_done(lat);
    chk(lat == LAT, "R9 second latency", lat, LAT);
    chk(t == e, "R9 second result", t, e);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_random();
    t_edges();
    t_busy_ignore();
    t_done_hold();
    t_back_to_back();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule